// File: doc/BRIEF.md
# Sequence-Unlocked Obfuscation Wrapper

This block puts a small registered datapath behind a mode controller that keeps the datapath's result wrong until a secret sequence of words has been presented on its input bus. After reset the controller sits in a locked start region. Each input word that arrives with its valid strobe is compared with the next word of the secret sequence. When the whole sequence has been matched in order, the controller enters the working mode and the datapath produces correct results from then on.

If any word does not match, the controller drops into a trap region of several states. It keeps stepping through those states on every clock and never reaches the working mode. Only a synchronous reset brings it back to the start of the locked region. While the block is not in working mode, the controller drives a non-zero corruption mask. That mask is XORed onto an internal node of the datapath, so every result produced in that time differs from the true value. The locked start states and the trap states together outnumber the single working state.

The secret sequence is fixed at build time through a parameter. The same input bus carries unlock words and operands, so every valid word accepted before unlock counts as an attempt at the sequence.

Top module: `keyseq_obf_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the controller in the first locked start state, with `unlocked` low and `out_valid` low.
- R2: In the locked start region, the controller checks one word per clock, and only in cycles where `in_valid` is high. The word checked is `in_a`, and the words are expected in the order `UNLOCK_KEY[31:24]`, `[23:16]`, `[15:8]`, `[7:0]` with the default 4×8-bit key. Cycles with `in_valid` low leave the progress unchanged, whatever `in_a` holds.
- R3: After the last sequence word has been accepted at a clock edge, `unlocked` is high from that edge on. It stays high until reset.
- R4: A valid word that does not match, presented while in the locked start region, moves the controller into the trap region. After that, `unlocked` stays low until reset, even if the complete correct sequence is then presented.
- R5: In the trap region the state advances on every clock through `ISO_STATES` (at least 4) distinct states. As a result, two identical inputs presented on consecutive cycles there give different `out_data` values.
- R6: In working mode, `out_data` equals `((in_a + in_b) mod 2^8) XOR rotate_left_1(in_a)` for the inputs of the previous valid cycle. `out_valid` is high exactly one clock after a cycle with `in_valid` high.
- R7: Whenever a valid input is taken while not in working mode, the result equals the correct value XOR a non-zero mask whose bit 0 is always set. The result therefore differs from the correct value in bit 0.
- R8: A reset taken from the trap region returns the controller to the first start state, and the correct sequence then unlocks it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word strobe |
| in_a | input | 8 | First operand; also carries unlock words |
| in_b | input | 8 | Second operand |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | 8 | Datapath result (corrupted while locked) |
| unlocked | output | 1 | High while in working mode |

## Verification
The hardest situation to reach from the ports is the combination of the trap region with a later presentation of the correct sequence. The trap has to be entered first, and only then can the correct key be shown to fail to unlock. The stimulus therefore sends a correct first word followed by a wrong one. It then sends two identical operands to see the trap state moving, and after that plays the full key. A following reset and a key run separated by idle cycles carrying wrong data show that reset is the only way out, and that strobe-less cycles are ignored.

// File: rtl/obf_pkg.sv
package obf_pkg;

  // Corruption pattern for a locked state index; bit 0 forced so it is never zero.
  function automatic logic [31:0] locked_mask(input int unsigned st);
    return (st * 32'd29) | 32'd1;
  endfunction

  // Rotate a byte-or-wider word left by one place (width given as argument).
  function automatic logic [31:0] rotl1(input logic [31:0] v, input int unsigned w);
    logic [31:0] m;
    m = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return (((v << 1) | (v >> (w - 1))) & m);
  endfunction

endpackage

// File: rtl/obf_mode_fsm.sv
module obf_mode_fsm #(
  parameter int W          = 8,
  parameter int KEY_WORDS  = 4,
  parameter logic [W*KEY_WORDS-1:0] UNLOCK_KEY = 32'hA53C_E17F,
  parameter int ISO_STATES = 4,
  localparam int NSTATES   = KEY_WORDS + 1 + ISO_STATES,
  localparam int SW        = $clog2(NSTATES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  in_word,
  output logic [SW-1:0] state_o,
  output logic          unlocked_o,
  output logic          in_iso_o,
  output logic          step_ok_o,
  output logic          step_bad_o,
  output logic [W-1:0]  mask_o
);
  import obf_pkg::*;

  localparam logic [SW-1:0] ST_NORMAL = SW'(KEY_WORDS);
  localparam logic [SW-1:0] ST_ISO0   = SW'(KEY_WORDS + 1);
  localparam logic [SW-1:0] ST_ISOL   = SW'(NSTATES - 1);

  logic [SW-1:0] st_q, st_d;
  logic          in_init;
  logic [W-1:0]  want_word;

  assign in_init  = (st_q < ST_NORMAL);
  assign in_iso_o = (st_q >= ST_ISO0);

  // Expected word for the current start state, first word in the top bits.
  always_comb begin
    want_word = '0;
    for (int i = 0; i < KEY_WORDS; i++) begin
      if (st_q == SW'(i)) want_word = UNLOCK_KEY[(KEY_WORDS-1-i)*W +: W];
    end
  end

  assign step_ok_o  = in_init && in_valid && (in_word == want_word);
  assign step_bad_o = in_init && in_valid && (in_word != want_word);

  always_comb begin
    st_d = st_q;
    if (step_ok_o)       st_d = st_q + SW'(1);
    else if (step_bad_o) st_d = ST_ISO0;
    else if (in_iso_o)   st_d = (st_q == ST_ISOL) ? ST_ISO0 : st_q + SW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else     st_q <= st_d;
  end

  assign state_o    = st_q;
  assign unlocked_o = (st_q == ST_NORMAL);
  assign mask_o     = unlocked_o ? '0 : W'(locked_mask(32'(st_q)));

endmodule

// File: rtl/obf_host_dp.sv
module obf_host_dp #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] mask,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  import obf_pkg::*;

  logic [W-1:0] n_sum, n_sum_x, n_rot, y;

  assign n_sum   = in_a + in_b;
  assign n_sum_x = n_sum ^ mask;          // selected node carrying the corruption
  assign n_rot   = W'(rotl1(32'(in_a), W));
  assign y       = n_sum_x ^ n_rot;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= y;
    end
  end

endmodule

// File: rtl/keyseq_obf_top.sv
module keyseq_obf_top #(
  parameter int W          = 8,
  parameter int KEY_WORDS  = 4,
  parameter logic [W*KEY_WORDS-1:0] UNLOCK_KEY = 32'hA53C_E17F,
  parameter int ISO_STATES = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         unlocked
);
  localparam int STATE_W = $clog2(KEY_WORDS + 1 + ISO_STATES);

  logic [STATE_W-1:0] fsm_state;
  logic               in_iso, step_ok, step_bad;
  logic [W-1:0]       obf_mask;

  obf_mode_fsm #(
    .W(W), .KEY_WORDS(KEY_WORDS), .UNLOCK_KEY(UNLOCK_KEY), .ISO_STATES(ISO_STATES)
  ) u_fsm (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_a),
    .state_o(fsm_state), .unlocked_o(unlocked), .in_iso_o(in_iso),
    .step_ok_o(step_ok), .step_bad_o(step_bad), .mask_o(obf_mask)
  );

  obf_host_dp #(.W(W)) u_host (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .mask(obf_mask), .out_valid(out_valid), .out_data(out_data)
  );

endmodule

// File: rtl/keyseq_obf_chk.sv
module keyseq_obf_chk #(
  parameter int W  = 8,
  parameter int SW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          out_valid,
  input logic          unlocked,
  input logic [SW-1:0] fsm_state,
  input logic          in_iso,
  input logic          step_ok,
  input logic          step_bad,
  input logic [W-1:0]  obf_mask
);

  a_r1_reset_start: assert property (@(posedge clk)
    rst |=> (fsm_state == '0 && !unlocked && !out_valid));

  a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !in_iso && !unlocked) |=> $stable(fsm_state));

  a_r3_unlock_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> $past(step_ok));

  a_r3_stay_unlocked: assert property (@(posedge clk) disable iff (rst)
    unlocked |=> unlocked);

  a_r4_enter_trap: assert property (@(posedge clk) disable iff (rst)
    step_bad |=> in_iso);

  a_r4_trap_sticky: assert property (@(posedge clk) disable iff (rst)
    in_iso |=> (in_iso && !unlocked));

  a_r5_trap_moves: assert property (@(posedge clk) disable iff (rst)
    in_iso |=> (fsm_state != $past(fsm_state)));

  a_r6_result_timing: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r7_mask_locked: assert property (@(posedge clk) disable iff (rst)
    !unlocked |-> obf_mask[0]);

  a_r7_mask_clear: assert property (@(posedge clk) disable iff (rst)
    unlocked |-> (obf_mask == '0));

endmodule

bind keyseq_obf_top keyseq_obf_chk #(.W(W), .SW(STATE_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .unlocked(unlocked), .fsm_state(fsm_state), .in_iso(in_iso),
  .step_ok(step_ok), .step_bad(step_bad), .obf_mask(obf_mask)
);

// File: tb/keyseq_obf_top_tb.sv
module keyseq_obf_top_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_a = '0, in_b = '0;
  logic       out_valid, unlocked;
  logic [7:0] out_data;

  keyseq_obf_top u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_data(out_data), .unlocked(unlocked)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [7:0] good;
    logic       locked;
    logic       must_differ;
  } exp_t;

  exp_t sb[$];
  int vecs = 0, errs = 0;
  bit done = 0;
  logic [7:0] key_w [4] = '{8'hA5, 8'h3C, 8'hE1, 8'h7F};
  int mode = 0;   // 0 start region, 1 working, 2 trap
  int kidx = 0;
  logic [7:0] prev_out = '0;

  function automatic logic [7:0] ref_res(logic [7:0] a, logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] ^ {a[6:0], a[7]};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] a, logic [7:0] b, bit differ);
    exp_t e;
    e.good = ref_res(a, b);
    e.locked = (mode != 1);
    e.must_differ = differ;
    sb.push_back(e);
    if (mode == 0) begin
      if (a == key_w[kidx]) begin
        kidx++;
        if (kidx == 4) mode = 1;
      end else mode = 2;
    end
    in_valid = 1'b1; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(int n, logic [7:0] junk);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b0; in_a = junk;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle(2, 8'h00);
    rst = 1'b0;
    mode = 0; kidx = 0;
    chk(!unlocked && !out_valid, "R1 reset locked", {unlocked, out_valid}, 0);
  endtask

  // Monitor: pops expected items as results appear.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb.size() == 0) chk(0, "R6 unexpected result", out_data, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        if (e.locked)
          chk(out_data[0] != e.good[0] && out_data != e.good, "R7 locked corrupt",
              out_data, e.good ^ 8'h01);
        else
          chk(out_data == e.good, "R6 working result", out_data, e.good);
        if (e.must_differ)
          chk(out_data != prev_out, "R5 trap state moves", out_data, prev_out);
        prev_out = out_data;
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++; vecs++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // Correct key with strobe-less gaps carrying wrong data (R2, R3)
    send(8'hA5, 8'h11, 0);
    idle(2, 8'h00);
    chk(!unlocked, "R2 partial key not unlocked", unlocked, 0);
    send(8'h3C, 8'h22, 0);
    idle(1, 8'hFF);
    send(8'hE1, 8'h33, 0);
    chk(!unlocked, "R2 three words not unlocked", unlocked, 0);
    send(8'h7F, 8'h44, 0);
    chk(unlocked, "R3 unlocked after key", unlocked, 1);

    // Working mode patterns (R6)
    send(8'h00, 8'h00, 0);
    send(8'hFF, 8'h01, 0);
    send(8'h80, 8'h80, 0);
    send(8'h5A, 8'hC3, 0);
    send(8'hA5, 8'h00, 0);
    idle(5, 8'h00);
    chk(unlocked, "R3 stays unlocked", unlocked, 1);

    // Wrong word -> trap, then correct key does not unlock (R4, R5)
    do_reset();
    send(8'hA5, 8'h10, 0);
    send(8'h00, 8'h10, 0);
    send(8'h12, 8'h34, 0);
    send(8'h12, 8'h34, 1);
    send(8'h12, 8'h34, 1);
    send(8'hA5, 8'h01, 0);
    send(8'h3C, 8'h02, 0);
    send(8'hE1, 8'h03, 0);
    send(8'h7F, 8'h04, 0);
    idle(3, 8'h00);
    chk(!unlocked, "R4 trap keeps locked", unlocked, 0);

    // Reset out of the trap, late correct key (R8)
    do_reset();
    send(8'hA5, 8'h00, 0);
    send(8'h3C, 8'h00, 0);
    send(8'hE1, 8'h00, 0);
    send(8'h7F, 8'h00, 0);
    chk(unlocked, "R8 unlock after reset from trap", unlocked, 1);
    send(8'h01, 8'h02, 0);
    send(8'hF0, 8'h0F, 0);

    // Wrong first word traps immediately (R4)
    idle(2, 8'h00);
    do_reset();
    send(8'h3C, 8'h00, 0);
    send(8'hA5, 8'h00, 0);
    send(8'h3C, 8'h00, 0);
    send(8'hE1, 8'h00, 0);
    send(8'h7F, 8'h00, 0);
    idle(3, 8'h00);
    chk(!unlocked, "R4 wrong first word traps", unlocked, 0);
    chk(sb.size() == 0, "R6 all results delivered", sb.size(), 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule